// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

This peripheral drives two pulse-width-modulated outputs from one system clock. Each channel takes its waveform from a 32-bit period word that holds two 16-bit counts: how many prescaled ticks the output stays high, and how many it then stays low. A single shared control word packs, for each channel, a two-bit choice among four tick inputs, a seven-bit prescaler, a clock gate and an output gate.

Software programs the counts and the control word through a plain 32-bit register port with byte offsets. Reads are combinational from the stored registers. The four tick inputs are single-cycle enables derived elsewhere from the system clock. A channel whose gates are both set runs its waveform continuously. When a gate is cleared, the output drops low at once. Inversion is obtained only by swapping the two counts, because no polarity control exists.

Top module: `dual_pwm_gen`

## Requirements
- R1: Offset 0x0 holds channel 0's period word, offset 0x4 holds channel 1's, and offset 0x8 holds the control word. Each reads back exactly what was last written. Offset 0xC reads zero, and writes to it change nothing.
- R2: After reset, every register reads zero and both outputs are low.
- R3: Control bits [5:4] (channel 0) and [7:6] (channel 1) select which bit of `src_tick_i` feeds the channel. Bits [14:8] (channel 0) and [22:16] (channel 1) hold N, and the channel advances once every N+1 selected ticks.
- R4: A channel's output can go high only when both its clock gate (bit 15 for channel 0, bit 23 for channel 1) and its output gate (bit 0 for channel 0, bit 1 for channel 1) are set. Otherwise it stays low.
- R5: When either gate of a running channel is cleared, its output is low in the cycle that follows the write, even in the middle of a high phase.
- R6: In steady state, each period holds the output high for H prescaled ticks and then low for L prescaled ticks. H is taken from bits [31:16] of the period word and L from bits [15:0].
- R7: A low count of 0 still gives one low prescaled tick per period. With H = 0xFFFF and L = 0, the output is high for 65535 ticks and low for 1.
- R8: With a high count of 0, the output never goes high.
- R9: A period word written while the channel runs takes effect only at the next period boundary. The current high and low phases keep their old lengths.
- R10: Setting the gates starts a fresh period. When H > 0, the output is high in the cycle after the enabling write.
- R11: The two channels run at the same time with independent settings, and neither disturbs the other's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| src_tick_i | input | 4 | Four tick enables, one per clock source |
| pwm_o | output | 2 | PWM outputs, bit 0 for channel 0 and bit 1 for channel 1 |

## Verification
The assertions assume three things. The tick inputs are synchronous single-cycle enables. The bus never writes the control word and a period word in the same cycle. Each channel's period word is stable at the moment its gates rise. The stimulus meets these assumptions: it drives ticks as fixed-rate patterns and issues one register write at a time on the falling edge. Random cases keep the counts and prescaler small, so that several whole periods fit in the run. Only one directed case uses the full 16-bit high count.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int CNT_W      = 16;
  localparam int DIV_W      = 7;
  localparam int SEL_W      = 2;
  localparam int NUM_SRC    = 1 << SEL_W;
  localparam int NUM_CH     = 2;
  // word index of the control register; period words sit at index = channel
  localparam int CTRL_IDX   = 2;
  // packed per-channel control fields
  localparam int OUTEN_LSB0 = 0;
  localparam int OUTEN_STEP = 1;
  localparam int SEL_LSB0   = 4;
  localparam int SEL_STEP   = 2;
  localparam int DIV_LSB0   = 8;
  localparam int DIV_STEP   = 8;
  localparam int CLKEN_LSB0 = 15;
  localparam int CLKEN_STEP = 8;
endpackage

// File: rtl/dual_pwm_regs.sv
module dual_pwm_regs
  import dual_pwm_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  per_q_o,
  output logic [DATA_W-1:0]              ctrl_q_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;

  assign idx        = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_per
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        per_q_o[c] <= '0;
      else if (we_i && idx == IDX_W'(c))  per_q_o[c] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ctrl_q_o <= '0;
    else if (we_i && idx == IDX_W'(CTRL_IDX))  ctrl_q_o <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (idx == IDX_W'(c)) rdata_o = per_q_o[c];
    if (idx == IDX_W'(CTRL_IDX)) rdata_o = ctrl_q_o;
  end
endmodule

// File: rtl/dual_pwm_presc.sv
module dual_pwm_presc #(
  parameter int DIV_W   = 7,
  parameter int SEL_W   = 2,
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output logic               ptick_o
);
  logic [DIV_W-1:0] pcnt_q;
  logic             src_hit;
  logic             at_end;

  assign src_hit = src_tick_i[sel_i];
  // >= so a prescaler shrunk on the fly cannot run past its limit
  assign at_end  = (pcnt_q >= div_i);
  assign ptick_o = run_i & src_hit & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pcnt_q <= '0;
    else if (!run_i)  pcnt_q <= '0;
    else if (src_hit) pcnt_q <= at_end ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/dual_pwm_chan.sv
module dual_pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ptick_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             pwm_o
);
  localparam int POS_W = CNT_W + 1;

  logic [POS_W-1:0] pos_q, pos_inc, len;
  logic [CNT_W-1:0] hi_q, lo_q;
  logic             wrap;

  // an empty low phase still costs one tick
  assign len     = {1'b0, hi_q} + ((lo_q == '0) ? POS_W'(1) : {1'b0, lo_q});
  assign pos_inc = pos_q + 1'b1;
  assign wrap    = (pos_inc >= len);
  assign pwm_o   = run_i & (pos_q < {1'b0, hi_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (!run_i || (ptick_i && wrap)) begin
      pos_q <= '0;
      hi_q  <= hi_i;
      lo_q  <= lo_i;
    end else if (ptick_i) begin
      pos_q <= pos_inc;
    end
  end
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import dual_pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [3:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [3:0]         src_tick_i,
  output logic [1:0]         pwm_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] per_q;
  logic [DATA_W-1:0]             ctrl_q;
  logic [NUM_CH-1:0]             run_w;
  logic [NUM_CH-1:0]             ptick_w;

  dual_pwm_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .per_q_o  (per_q),
    .ctrl_q_o (ctrl_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int SL = SEL_LSB0   + SEL_STEP   * c;
    localparam int DL = DIV_LSB0   + DIV_STEP   * c;
    localparam int CE = CLKEN_LSB0 + CLKEN_STEP * c;
    localparam int OE = OUTEN_LSB0 + OUTEN_STEP * c;

    assign run_w[c] = ctrl_q[CE] & ctrl_q[OE];

    dual_pwm_presc #(
      .DIV_W   (DIV_W),
      .SEL_W   (SEL_W),
      .NUM_SRC (NUM_SRC)
    ) u_presc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_w[c]),
      .sel_i      (ctrl_q[SL +: SEL_W]),
      .div_i      (ctrl_q[DL +: DIV_W]),
      .src_tick_i (src_tick_i),
      .ptick_o    (ptick_w[c])
    );

    dual_pwm_chan #(
      .CNT_W (CNT_W)
    ) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_w[c]),
      .ptick_i (ptick_w[c]),
      .hi_i    (per_q[c][2*CNT_W-1:CNT_W]),
      .lo_i    (per_q[c][CNT_W-1:0]),
      .pwm_o   (pwm_o[c])
    );
  end
endmodule

// File: rtl/dual_pwm_chk.sv
module dual_pwm_chk
  import dual_pwm_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_SRC-1:0]            src_tick_i,
  input logic [NUM_CH-1:0]             pwm_o,
  input logic [NUM_CH-1:0][DATA_W-1:0] per_q,
  input logic [DATA_W-1:0]             ctrl_q,
  input logic [NUM_CH-1:0]             run_w,
  input logic [NUM_CH-1:0]             ptick_w
);
  logic unused_chk;
  assign unused_chk = ^{per_q, ctrl_q};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    localparam int SL = SEL_LSB0 + SEL_STEP * c;

    p_tick_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptick_w[c] |-> src_tick_i[ctrl_q[SL +: SEL_W]]);

    p_gate_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_w[c] |-> !pwm_o[c]);

    p_cut_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_w[c]) |-> !pwm_o[c]);

    p_rise_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(pwm_o[c]) && $past(run_w[c])) |-> $past(ptick_w[c]));

    p_start_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(run_w[c]) && per_q[c][2*CNT_W-1:CNT_W] != '0) |-> pwm_o[c]);
  end
endmodule

bind dual_pwm_gen dual_pwm_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_tick_i (src_tick_i),
  .pwm_o      (pwm_o),
  .per_q      (per_q),
  .ctrl_q     (ctrl_q),
  .run_w      (run_w),
  .ptick_w    (ptick_w)
);

// File: tb/dual_pwm_gen_tb.sv
`timescale 1ns/1ps
module dual_pwm_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  tick = '0;
  logic [1:0]  pwm;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  dual_pwm_gen u_dut (
    .clk_i (clk), .rst_ni (rst_n), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .src_tick_i (tick), .pwm_o (pwm)
  );

  // fixed-rate tick sources: every 1, 2, 3, 5 cycles
  always @(negedge clk) begin
    cyc++;
    tick[0] <= 1'b1;
    tick[1] <= (cyc % 2 == 0);
    tick[2] <= (cyc % 3 == 0);
    tick[3] <= (cyc % 5 == 0);
  end

  function automatic int src_per(int sel);
    case (sel)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_f(int ch, int sel, int div, bit ce, bit oe);
    logic [31:0] v = '0;
    v[ch]            = oe;
    v[4 + 2*ch +: 2] = sel[1:0];
    v[8 + 8*ch +: 7] = div[6:0];
    v[15 + 8*ch]     = ce;
    return v;
  endfunction

  function automatic int exp_hi(int h, int div, int sel);
    return h * (div + 1) * src_per(sel);
  endfunction

  function automatic int exp_lo(int l, int div, int sel);
    return ((l == 0) ? 1 : l) * (div + 1) * src_per(sel);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic run_len(int ch, bit lvl, int lim, output int n);
    n = 0;
    while (pwm[ch] == lvl && n < lim) begin n++; @(negedge clk); end
  endtask

  task automatic count_high(int ch, int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin @(negedge clk); if (pwm[ch]) n++; end
  endtask

  task automatic steady(int ch, output int h, output int l);
    int d;
    run_len(ch, 1'b1, 5000, d);
    run_len(ch, 1'b0, 5000, d);
    run_len(ch, 1'b1, 5000, h);
    run_len(ch, 1'b0, 5000, l);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, va, vb, vc;
    int h, l, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    @(negedge clk);
    check("R2 pwm", pwm, 0);
    rd(4'h0, d); check("R2 per0", d, 0);
    rd(4'h4, d); check("R2 per1", d, 0);
    rd(4'h8, d); check("R2 ctrl", d, 0);

    // R1: readback and unmapped offset
    va = $urandom; vb = $urandom; vc = $urandom;
    wr(4'h0, va); wr(4'h4, vb); wr(4'h8, vc);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R1 per0", d, va);
    rd(4'h4, d); check("R1 per1", d, vb);
    rd(4'h8, d); check("R1 ctrl", d, vc);
    rd(4'hC, d); check("R1 hole", d, 0);
    wr(4'h8, 32'h0);

    // R4: a single gate is not enough
    wr(4'h0, {16'd3, 16'd3});
    wr(4'h8, ctrl_f(0, 0, 0, 1'b0, 1'b1));
    count_high(0, 40, n); check("R4 oe only", n, 0);
    wr(4'h8, ctrl_f(0, 0, 0, 1'b1, 1'b0));
    count_high(0, 40, n); check("R4 ce only", n, 0);

    // R10 then R5
    wr(4'h8, ctrl_f(0, 0, 0, 1'b1, 1'b1));
    check("R10 start high", pwm[0], 1);
    wr(4'h8, ctrl_f(0, 0, 0, 1'b1, 1'b0));
    check("R5 cut", pwm[0], 0);
    count_high(0, 20, n); check("R5 stays low", n, 0);

    // R8: zero high count
    wr(4'h0, {16'd0, 16'd5});
    wr(4'h8, ctrl_f(0, 0, 0, 1'b1, 1'b1));
    count_high(0, 40, n); check("R8 no high", n, 0);
    wr(4'h8, 32'h0);

    // R9: write mid high phase, old lengths finish first
    wr(4'h0, {16'd4, 16'd4});
    wr(4'h8, ctrl_f(0, 0, 0, 1'b1, 1'b1));
    wr(4'h0, {16'd2, 16'd6});
    run_len(0, 1'b1, 100, h); check("R9 rest of old high", h, 2);
    run_len(0, 1'b0, 100, l); check("R9 old low", l, 4);
    run_len(0, 1'b1, 100, h); check("R9 new high", h, 2);
    run_len(0, 1'b0, 100, l); check("R9 new low", l, 6);
    wr(4'h8, 32'h0);

    // R6, R3, R11: both channels random, measured in steady state
    for (int it = 0; it < 10; it++) begin
      int hi0 = 1 + $urandom % 6, lo0 = $urandom % 7, dv0 = $urandom % 4, sl0 = $urandom % 4;
      int hi1 = 1 + $urandom % 6, lo1 = $urandom % 7, dv1 = $urandom % 4, sl1 = $urandom % 4;
      wr(4'h0, {hi0[15:0], lo0[15:0]});
      wr(4'h4, {hi1[15:0], lo1[15:0]});
      wr(4'h8, ctrl_f(0, sl0, dv0, 1'b1, 1'b1) | ctrl_f(1, sl1, dv1, 1'b1, 1'b1));
      steady(0, h, l);
      check("R6 R3 ch0 high", h, exp_hi(hi0, dv0, sl0));
      check("R6 R7 ch0 low", l, exp_lo(lo0, dv0, sl0));
      steady(1, h, l);
      check("R11 R3 ch1 high", h, exp_hi(hi1, dv1, sl1));
      check("R11 R7 ch1 low", l, exp_lo(lo1, dv1, sl1));
      wr(4'h8, 32'h0);
    end

    // R7: full high count with zero low count on channel 1
    wr(4'h4, {16'hFFFF, 16'h0000});
    wr(4'h8, ctrl_f(1, 0, 0, 1'b1, 1'b1));
    run_len(1, 1'b1, 70000, h); check("R7 max high", h, 65535);
    run_len(1, 1'b0, 100, l);   check("R7 one low tick", l, 1);
    check("R7 high again", pwm[1], 1);
    wr(4'h8, 32'h0);

    finish_run();
  end
endmodule